// File: doc/BRIEF.md
# Edge-Selectable Wakeup Interrupt Unit

This block watches an 8-pin input port. It synchronizes every pin and records a chosen transition on each one in a sticky pending bit. Software picks the transition for each pin. A zero in the edge-select bit arms the pin for a low-to-high change, and a one arms it for a high-to-low change. Every pin feeds one common service request, so there is a single request line and no per-pin vector.

The same pending bits drive two outputs. The wakeup output asks a low-power controller to leave halt or idle whenever any enabled pin has a pending edge. The interrupt output is that same condition, further gated by a port-level enable and the global interrupt enable. When the port enable is low, a wakeup still happens but no interrupt is requested, so the processor resumes straight after its halt or idle instruction. When the port enable is high, the service routine runs first.

A small register bus gives access to the enable, edge-select and pending registers. Writes are synchronous and reads are combinational.

Top module: `wake_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable, edge-select and pending registers read 0, and irq_o and wake_o are 0.
- R2: With edge-select bit n at 0, a low-to-high change on pin_i[n] sets pending bit n. The bit reads as set after the third rising clock edge following the change, and not after the second.
- R3: With edge-select bit n at 1, a high-to-low change on pin_i[n] sets pending bit n with the same latency.
- R4: A change on a pin in the direction its edge-select bit does not select leaves pending unchanged.
- R5: Pending bits latch whether or not their enable bit is set. wake_o is 1 exactly when some pending bit has its enable bit set.
- R6: irq_o is 1 only when wake_o, port_en_i and gie_i are all 1. With port_en_i or gie_i at 0, wake_o still reflects the enabled pending bits.
- R7: Writing the pending register (address 2) clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a pending bit.
- R8: When a selected edge and a pending-register write that clears the same bit land on the same clock edge, the bit ends up set.
- R9: Changing an edge-select bit while its pin is steady creates no pending bit.
- R10: Pins are independent. Selected edges on several pins in the same cycle set all of the matching pending bits.
- R11: Register addresses: 0 is enable, 1 is edge-select, 2 is pending, and 3 reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Asynchronous port pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| port_en_i | input | 1 | Port-level interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wakeup request to the low-power controller |

## Verification
A software clear of the pending register and a new selected edge on a pin can land on the same clock edge. The bench provokes this by moving one pin two cycles before it issues a clear-all write, so that the edge reaches the pending logic on exactly the edge that registers the write. The bench then expects only that pin's bit to remain, with every earlier bit gone. A similar coincidence is checked between an edge-select write and a steady pin, where the expected pending value is zero.

// File: rtl/wkirq_pkg.sv
// Shared constants for the wakeup interrupt unit.
// Assumes a 2-bit register address space.
package wkirq_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] REG_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] REG_EDGE   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_PEND   = 2'd2;
endpackage

// File: rtl/wkirq_sync.sv
// Multi-stage synchronizer for the port pins, plus one history register.
// Assumes pins are asynchronous to clk. lvl_o is the synchronized level and
// prev_o is that level one cycle earlier. Reset drives both to 0.
module wkirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture raw pins into the first stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                // shift the level down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    // keep the last synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= chain_q[STAGES-1];
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/wkirq_edge.sv
// Per-pin edge detector with a selectable polarity.
// Assumes lvl_i and prev_i are synchronous. A select bit of 1 picks falling
// edges and 0 picks rising edges. Polarity acts on the transition only, so a
// steady pin never produces an edge, whatever the select bit does.
module wkirq_edge #(
    parameter int W = 8
) (
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] fall_sel_i,
    output logic [W-1:0] edge_o
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic changed;
            // a transition happened on this pin
            assign changed = lvl_i[i] ^ prev_i[i];
            // keep only the direction this pin is armed for
            assign edge_o[i] = changed & (fall_sel_i[i] ? prev_i[i] : lvl_i[i]);
        end
    endgenerate
endmodule

// File: rtl/wkirq_regs.sv
// Register bank: enable, edge-select and sticky pending bits.
// Assumes a single-cycle write strobe. A pending write can only clear bits,
// and an incoming edge wins over a clear on the same clock edge.
module wkirq_regs
    import wkirq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [W-1:0]      wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [W-1:0]      edge_i,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      sel_o,
    output logic [W-1:0]      pend_o,
    output logic [W-1:0]      rd_data_o
);
    logic [W-1:0] keep_mask;

    // clear mask: bits written as 0 drop, all others kept
    always_comb begin
        keep_mask = '1;
        if (wr_en_i && wr_addr_i == REG_PEND) keep_mask = wr_data_i;
    end

    // enable and edge-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= '0;
            sel_o <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == REG_ENABLE) en_o  <= wr_data_i;
            if (wr_addr_i == REG_EDGE)   sel_o <= wr_data_i;
        end
    end

    // sticky pending bits, edge has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & keep_mask) | edge_i;
    end

    // combinational read mux
    always_comb begin
        case (rd_addr_i)
            REG_ENABLE: rd_data_o = en_o;
            REG_EDGE:   rd_data_o = sel_o;
            REG_PEND:   rd_data_o = pend_o;
            default:    rd_data_o = '0;
        endcase
    end

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i != '0) |=> ((pend_o & $past(edge_i)) == $past(edge_i)));

    // R7
    no_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(edge_i)) == '0));
endmodule

// File: rtl/wake_irq_unit.sv
// Top of the edge-selectable wakeup interrupt unit.
// Assumes pins are asynchronous. The pending bits serve as both the wakeup
// source and the interrupt source. The interrupt is further gated by the
// port enable and the global enable.
module wake_irq_unit #(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [N_PINS-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [N_PINS-1:0] rd_data_o,
    input  logic              port_en_i,
    input  logic              gie_i,
    output logic              irq_o,
    output logic              wake_o
);
    logic [N_PINS-1:0] lvl, prev, edges, en, sel, pend;

    wkirq_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev)
    );

    wkirq_edge #(.W(N_PINS)) u_edge (
        .lvl_i(lvl), .prev_i(prev), .fall_sel_i(sel), .edge_o(edges)
    );

    wkirq_regs #(.W(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .edge_i(edges),
        .en_o(en), .sel_o(sel), .pend_o(pend), .rd_data_o(rd_data_o)
    );

    // shared wakeup from any enabled pending bit
    assign wake_o = |(pend & en);
    // interrupt needs port and global enables as well
    assign irq_o  = wake_o & port_en_i & gie_i;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && en == '0 && sel == '0));

    genvar i;
    generate
        for (i = 0; i < N_PINS; i++) begin : g_chk
            // R2
            rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(lvl[i]) && !sel[i]) |=> pend[i]);
            // R3
            fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(lvl[i]) && sel[i]) |=> pend[i]);
        end
    endgenerate
endmodule

// File: tb/tb_wake_irq_unit.sv
module tb_wake_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       port_en_i = 1'b0;
    logic       gie_i = 1'b0;
    logic       irq_o, wake_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] addr;
        logic [7:0] rd;
        logic       irq;
        logic       wake;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    wake_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .port_en_i(port_en_i), .gie_i(gie_i),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    // monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                rd_addr_i = it.addr;
                #0.5;
                n_tests++;
                if (rd_data_o !== it.rd || irq_o !== it.irq || wake_o !== it.wake) begin
                    n_fail++;
                    $display("FAIL %s: rd=%h irq=%b wake=%b expected rd=%h irq=%b wake=%b",
                             it.tag, rd_data_o, irq_o, wake_o, it.rd, it.irq, it.wake);
                end
            end
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // driver side: push an expectation and let the monitor consume it
    task automatic expect_item(string tag, logic [1:0] a, logic [7:0] rd,
                               logic irq, logic wake);
        item_t it;
        it.tag = tag; it.addr = a; it.rd = rd; it.irq = irq; it.wake = wake;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        cyc();
        wr_en_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R1 reset values
        expect_item("R1 enable", 2'd0, 8'h00, 1'b0, 1'b0);
        expect_item("R1 edgesel", 2'd1, 8'h00, 1'b0, 1'b0);
        expect_item("R1 pending", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        port_en_i = 1'b1; gie_i = 1'b1;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        // R2 rising edge latency
        pin_i = 8'h01;
        cyc(2);
        expect_item("R2 not yet", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        cyc();
        expect_item("R2 rise", 2'd2, 8'h01, 1'b1, 1'b1);
        cyc();
        wr(2'd2, 8'h00);
        expect_item("R7 clear", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        // R4 falling on a rising-armed pin
        pin_i = 8'h00;
        cyc(4);
        expect_item("R4 fall ignored", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        // R3 falling selection on pin 1
        wr(2'd1, 8'h02);
        pin_i = 8'h02;
        cyc(4);
        expect_item("R4 rise ignored", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        pin_i = 8'h00;
        cyc(4);
        expect_item("R3 fall", 2'd2, 8'h02, 1'b1, 1'b1);
        cyc();
        // R7 writing ones keeps, writing zero clears
        wr(2'd2, 8'hFF);
        expect_item("R7 ones keep", 2'd2, 8'h02, 1'b1, 1'b1);
        cyc();
        wr(2'd2, 8'hFD);
        expect_item("R7 zero clears", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        // R9 select changes on steady pins
        wr(2'd1, 8'h00);
        pin_i = 8'h10;
        cyc(4);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h10);
        cyc(4);
        expect_item("R9 no spurious", 2'd2, 8'h00, 1'b0, 1'b0);
        cyc();
        wr(2'd1, 8'h00);
        // R5 pending latches while disabled
        wr(2'd0, 8'h00);
        pin_i = 8'h18;
        cyc(4);
        expect_item("R5 latched disabled", 2'd2, 8'h08, 1'b0, 1'b0);
        cyc();
        wr(2'd0, 8'h08);
        expect_item("R5 enabled wake", 2'd2, 8'h08, 1'b1, 1'b1);
        cyc();
        // R6 gating by port enable and global enable
        port_en_i = 1'b0;
        expect_item("R6 port off", 2'd2, 8'h08, 1'b0, 1'b1);
        cyc();
        port_en_i = 1'b1; gie_i = 1'b0;
        expect_item("R6 gie off", 2'd2, 8'h08, 1'b0, 1'b1);
        cyc();
        gie_i = 1'b1;
        expect_item("R6 both on", 2'd2, 8'h08, 1'b1, 1'b1);
        cyc();
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        // R10 several pins at once
        pin_i = 8'hE7;
        cyc(4);
        expect_item("R10 multi", 2'd2, 8'hE7, 1'b1, 1'b1);
        cyc();
        // R8 clear and new edge on the same clock edge
        pin_i = 8'hEF;
        cyc(2);
        wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 8'h00;
        cyc();
        wr_en_i = 1'b0;
        expect_item("R8 edge wins", 2'd2, 8'h08, 1'b1, 1'b1);
        cyc();
        // R11 reserved address
        wr(2'd3, 8'hAA);
        expect_item("R11 reserved", 2'd3, 8'h00, 1'b1, 1'b1);
        expect_item("R11 enable intact", 2'd0, 8'hFF, 1'b1, 1'b1);
        cyc(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule